// File: doc/BRIEF.md
# Dual-Issue Pairing Check

This block sits at the issue point of a two-wide in-order pipeline. Each cycle it looks at the two oldest instructions, called first and second in program order. It decides whether only the first issues or whether both issue together. The machine has two issue slots. The integer slot accepts integer ALU operations, loads, stores and branches. The FP slot accepts only floating-point operations. A pair can leave together only when it holds one instruction of each kind.

The decision uses the two class codes and the six register specifiers of the pair. These are one destination and two sources per instruction, and each has its own enable bit. The second instruction is held back when it depends on the first through the first's destination. An external stall input blocks issue for the cycle. Latency interlocks between cycles belong to the logic that drives that stall input.

The decision is registered. Inputs sampled at one rising edge show up on the outputs until the next edge. The consumed count tells the fetch side how many instructions to retire from the head of its queue.

Top module: `dual_issue_pair_check`

## Requirements
- R1: While reset is asserted and after it is released, before the first sampled decision, all outputs are 0.
- R2: The class code is 3 bits. 3'd0 is an integer ALU op, 3'd1 a load, 3'd2 a store, 3'd3 a branch, and 3'd4 an FP op. Only 3'd4 uses the FP slot. Every other code, including the unused codes 3'd5 to 3'd7, uses the integer slot.
- R3: If the first instruction is valid and no stall is present, it issues in the slot of its class. The outputs give that decision in the cycle after the inputs are sampled, and the number of raised slot enables always equals consumed_o.
- R4: A sampled stall gives consumed_o = 0 and no slot enable, whatever the instructions are.
- R5: Issue is in order. If the first instruction is not valid, nothing issues, even when the second is valid.
- R6: Both instructions issue (consumed_o = 2, both slot enables high) when all of these hold: both are valid, no stall is present, one is FP and the other is not, and no dependence exists. first_to_fp_o is 1 exactly when the first instruction has issued into the FP slot.
- R7: If both instructions need the same slot, only the first issues.
- R8: If the second instruction has an enabled source equal to the first's enabled destination (read after write), only the first issues.
- R9: If the second instruction's enabled destination equals the first's enabled destination (write after write), only the first issues.
- R10: A branch in the first position pairs with an FP second instruction under the same rules as any other integer-slot op.
- R11: A specifier whose enable bit is 0 takes no part in the dependence check, even when its value matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall_i | input | 1 | Blocks all issue this cycle |
| i0_valid_i | input | 1 | First instruction present |
| i0_class_i | input | 3 | First instruction class code |
| i0_dst_i | input | REG_W | First destination specifier |
| i0_dst_we_i | input | 1 | First writes its destination |
| i0_srca_i | input | REG_W | First source A specifier |
| i0_srca_en_i | input | 1 | First reads source A |
| i0_srcb_i | input | REG_W | First source B specifier |
| i0_srcb_en_i | input | 1 | First reads source B |
| i1_valid_i | input | 1 | Second instruction present |
| i1_class_i | input | 3 | Second instruction class code |
| i1_dst_i | input | REG_W | Second destination specifier |
| i1_dst_we_i | input | 1 | Second writes its destination |
| i1_srca_i | input | REG_W | Second source A specifier |
| i1_srca_en_i | input | 1 | Second reads source A |
| i1_srcb_i | input | REG_W | Second source B specifier |
| i1_srcb_en_i | input | 1 | Second reads source B |
| int_issue_o | output | 1 | Integer slot issues this cycle |
| fp_issue_o | output | 1 | FP slot issues this cycle |
| first_to_fp_o | output | 1 | First instruction is in the FP slot |
| consumed_o | output | 2 | Instructions issued: 0, 1 or 2 |

## Verification
Some properties are checked by assertions on every cycle. These are the stall blocking issue, the in-order rule for an empty first position, single issue on a slot clash or on a flagged dependence, and the agreement between slot enables, slot assignment and consumed count. The bench sweeps every pair of class codes against every valid and stall combination and six register patterns. Only these scenarios show that the right slot is chosen for each code, that branches pair with FP ops, and that disabled specifiers are really ignored. The assertions take the dependence flag as given, so it is the bench that confirms read-after-write and write-after-write matches are detected on the right fields.

// File: rtl/pairchk_pkg.sv
package pairchk_pkg;

  localparam logic [2:0] CLS_ALU    = 3'd0;
  localparam logic [2:0] CLS_LOAD   = 3'd1;
  localparam logic [2:0] CLS_STORE  = 3'd2;
  localparam logic [2:0] CLS_BRANCH = 3'd3;
  localparam logic [2:0] CLS_FP     = 3'd4;

  typedef enum logic {SLOT_INT = 1'b0, SLOT_FP = 1'b1} slot_e;

  // R2: only the FP code steers into the FP slot
  function automatic slot_e slot_of_class(input logic [2:0] cls);
    return (cls == CLS_FP) ? SLOT_FP : SLOT_INT;
  endfunction

  function automatic logic [1:0] count_issues(input logic a, input logic b);
    return {1'b0, a} + {1'b0, b};
  endfunction

endpackage

// File: rtl/pairchk_decode.sv
module pairchk_decode
  import pairchk_pkg::*;
(
  input  logic       valid_i,
  input  logic [2:0] class_i,
  output logic       live_o,
  output slot_e      slot_o
);
  assign live_o = valid_i;
  assign slot_o = slot_of_class(class_i);
endmodule

// File: rtl/pairchk_dep.sv
module pairchk_dep #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] first_dst_i,
  input  logic             first_we_i,
  input  logic [REG_W-1:0] second_srca_i,
  input  logic             second_srca_en_i,
  input  logic [REG_W-1:0] second_srcb_i,
  input  logic             second_srcb_en_i,
  input  logic [REG_W-1:0] second_dst_i,
  input  logic             second_we_i,
  output logic             raw_hit_o,
  output logic             waw_hit_o,
  output logic             dep_hit_o
);
  // R11: a specifier only counts when both sides are enabled
  function automatic logic spec_match(input logic [REG_W-1:0] a, input logic a_en,
                                      input logic [REG_W-1:0] b, input logic b_en);
    return a_en && b_en && (a == b);
  endfunction

  // R8
  assign raw_hit_o = spec_match(first_dst_i, first_we_i, second_srca_i, second_srca_en_i)
                   | spec_match(first_dst_i, first_we_i, second_srcb_i, second_srcb_en_i);
  // R9
  assign waw_hit_o = spec_match(first_dst_i, first_we_i, second_dst_i, second_we_i);
  assign dep_hit_o = raw_hit_o | waw_hit_o;
endmodule

// File: rtl/pairchk_arbiter.sv
module pairchk_arbiter
  import pairchk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stall_i,
  input  logic       live0_i,
  input  logic       live1_i,
  input  slot_e      slot0_i,
  input  slot_e      slot1_i,
  input  logic       dep_hit_i,
  output logic       int_issue_o,
  output logic       fp_issue_o,
  output logic       first_to_fp_o,
  output logic [1:0] consumed_o
);
  logic first_go;
  logic slot_clash;
  logic second_go;

  assign first_go   = live0_i && !stall_i;                       // R4, R5
  assign slot_clash = (slot0_i == slot1_i);                      // R7
  assign second_go  = first_go && live1_i && !slot_clash && !dep_hit_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_issue_o   <= 1'b0;
      fp_issue_o    <= 1'b0;
      first_to_fp_o <= 1'b0;
      consumed_o    <= 2'd0;
    end else begin
      int_issue_o   <= (first_go && slot0_i == SLOT_INT) || (second_go && slot1_i == SLOT_INT);
      fp_issue_o    <= (first_go && slot0_i == SLOT_FP)  || (second_go && slot1_i == SLOT_FP);
      first_to_fp_o <= first_go && slot0_i == SLOT_FP;
      consumed_o    <= count_issues(first_go, second_go);
    end
  end

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> (consumed_o == 2'd0 && !int_issue_o && !fp_issue_o)); // R4
  AST_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    !live0_i |=> (consumed_o == 2'd0)); // R5
  AST_SAME_SLOT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (live0_i && live1_i && slot0_i == slot1_i) |=> (consumed_o != 2'd2)); // R7
  AST_DEP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    dep_hit_i |=> (consumed_o != 2'd2)); // R8
  AST_ISSUE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({int_issue_o, fp_issue_o}) == consumed_o); // R3
  AST_FP_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    first_to_fp_o |-> fp_issue_o); // R6
  AST_PAIR_FILLS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (consumed_o == 2'd2) |-> (int_issue_o && fp_issue_o)); // R6
endmodule

// File: rtl/dual_issue_pair_check.sv
module dual_issue_pair_check
  import pairchk_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall_i,
  input  logic             i0_valid_i,
  input  logic [2:0]       i0_class_i,
  input  logic [REG_W-1:0] i0_dst_i,
  input  logic             i0_dst_we_i,
  input  logic [REG_W-1:0] i0_srca_i,
  input  logic             i0_srca_en_i,
  input  logic [REG_W-1:0] i0_srcb_i,
  input  logic             i0_srcb_en_i,
  input  logic             i1_valid_i,
  input  logic [2:0]       i1_class_i,
  input  logic [REG_W-1:0] i1_dst_i,
  input  logic             i1_dst_we_i,
  input  logic [REG_W-1:0] i1_srca_i,
  input  logic             i1_srca_en_i,
  input  logic [REG_W-1:0] i1_srcb_i,
  input  logic             i1_srcb_en_i,
  output logic             int_issue_o,
  output logic             fp_issue_o,
  output logic             first_to_fp_o,
  output logic [1:0]       consumed_o
);
  localparam int NUM_POS = 2;

  logic [NUM_POS-1:0] valid_vec;
  logic [2:0]         class_vec [NUM_POS];
  logic [NUM_POS-1:0] live_vec;
  slot_e              slot_vec  [NUM_POS];

  assign valid_vec    = {i1_valid_i, i0_valid_i};
  assign class_vec[0] = i0_class_i;
  assign class_vec[1] = i1_class_i;

  for (genvar p = 0; p < NUM_POS; p++) begin : g_pos
    pairchk_decode u_dec (
      .valid_i (valid_vec[p]),
      .class_i (class_vec[p]),
      .live_o  (live_vec[p]),
      .slot_o  (slot_vec[p])
    );
  end

  // i0 source specifiers do not affect pairing: the second instruction
  // overwriting a first-instruction source is harmless when reads happen at issue.
  logic unused_first_srcs;
  assign unused_first_srcs = ^{i0_srca_i, i0_srca_en_i, i0_srcb_i, i0_srcb_en_i};

  logic raw_hit, waw_hit, dep_hit;

  pairchk_dep #(.REG_W(REG_W)) u_dep (
    .first_dst_i      (i0_dst_i),
    .first_we_i       (i0_dst_we_i),
    .second_srca_i    (i1_srca_i),
    .second_srca_en_i (i1_srca_en_i),
    .second_srcb_i    (i1_srcb_i),
    .second_srcb_en_i (i1_srcb_en_i),
    .second_dst_i     (i1_dst_i),
    .second_we_i      (i1_dst_we_i),
    .raw_hit_o        (raw_hit),
    .waw_hit_o        (waw_hit),
    .dep_hit_o        (dep_hit)
  );

  pairchk_arbiter u_arb (
    .clk           (clk),
    .rst_n         (rst_n),
    .stall_i       (stall_i),
    .live0_i       (live_vec[0]),
    .live1_i       (live_vec[1]),
    .slot0_i       (slot_vec[0]),
    .slot1_i       (slot_vec[1]),
    .dep_hit_i     (dep_hit),
    .int_issue_o   (int_issue_o),
    .fp_issue_o    (fp_issue_o),
    .first_to_fp_o (first_to_fp_o),
    .consumed_o    (consumed_o)
  );

  AST_RAW_FLAGS_DEP: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_hit || waw_hit) |=> (consumed_o != 2'd2)); // R9
endmodule

// File: tb/dual_issue_pair_check_tb_top.sv
module dual_issue_pair_check_tb_top;
  localparam int RW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stall;
  logic v0, we0, sa0e, sb0e, v1, we1, sa1e, sb1e;
  logic [2:0] c0, c1;
  logic [RW-1:0] d0, sa0, sb0, d1, sa1, sb1;
  logic int_iss, fp_iss, f2fp;
  logic [1:0] cons;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  dual_issue_pair_check #(.REG_W(RW)) dut_i (
    .clk(clk), .rst_n(rst_n), .stall_i(stall),
    .i0_valid_i(v0), .i0_class_i(c0), .i0_dst_i(d0), .i0_dst_we_i(we0),
    .i0_srca_i(sa0), .i0_srca_en_i(sa0e), .i0_srcb_i(sb0), .i0_srcb_en_i(sb0e),
    .i1_valid_i(v1), .i1_class_i(c1), .i1_dst_i(d1), .i1_dst_we_i(we1),
    .i1_srca_i(sa1), .i1_srca_en_i(sa1e), .i1_srcb_i(sb1), .i1_srcb_en_i(sb1e),
    .int_issue_o(int_iss), .fp_issue_o(fp_iss), .first_to_fp_o(f2fp), .consumed_o(cons)
  );

  task automatic check(input string req, input logic [4:0] got, input logic [4:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: {int,fp,first_fp,consumed} got %b expected %b", req, got, exp);
    end
  endtask

  // pattern: 0 none, 1 RAW srcA, 2 RAW srcB, 3 WAW, 4 srcA match but disabled, 5 match on unwritten dst
  task automatic set_regs(input int pat);
    d0 = 5'd5; we0 = 1'b1; sa0 = 5'd1; sa0e = 1'b1; sb0 = 5'd2; sb0e = 1'b1;
    d1 = 5'd11; we1 = 1'b1; sa1 = 5'd7; sa1e = 1'b1; sb1 = 5'd9; sb1e = 1'b1;
    case (pat)
      1: sa1 = 5'd5;
      2: sb1 = 5'd5;
      3: d1 = 5'd5;
      4: begin sa1 = 5'd5; sa1e = 1'b0; end
      5: begin we0 = 1'b0; sa1 = 5'd5; d1 = 5'd5; end
      default: ;
    endcase
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : stim
    stall = 1'b0; v0 = 1'b1; v1 = 1'b1; c0 = 3'd0; c1 = 3'd4;
    set_regs(0);
    repeat (3) @(negedge clk);
    check("R1 in reset", {int_iss, fp_iss, f2fp, cons}, 5'b0);
    rst_n = 1'b1;
    #1;
    check("R1 after release", {int_iss, fp_iss, f2fp, cons}, 5'b0);

    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        for (int pat = 0; pat < 6; pat++) begin
          for (int ctl = 0; ctl < 8; ctl++) begin
            logic fp0, fp1, hz, s, vv0, vv1;
            int n;
            string tag;
            logic [4:0] exp;
            @(negedge clk);
            vv0 = ctl[0]; vv1 = ctl[1]; s = ctl[2];
            c0 = a[2:0]; c1 = b[2:0]; v0 = vv0; v1 = vv1; stall = s;
            set_regs(pat);
            fp0 = (a == 4); fp1 = (b == 4);
            hz  = (pat >= 1 && pat <= 3);
            if (s || !vv0) n = 0;
            else if (vv1 && (fp0 ^ fp1) && !hz) n = 2;
            else n = 1;
            exp[4] = (n == 2) || (n == 1 && !fp0);
            exp[3] = (n == 2) || (n == 1 && fp0);
            exp[2] = (n != 0) && fp0;
            exp[1:0] = n[1:0];
            if (s) tag = "R4";
            else if (!vv0) tag = "R5";
            else if (a > 4 || b > 4) tag = "R2";
            else if (vv1 && fp0 == fp1) tag = "R7";
            else if (vv1 && (pat == 1 || pat == 2)) tag = "R8";
            else if (vv1 && pat == 3) tag = "R9";
            else if (vv1 && (pat == 4 || pat == 5)) tag = "R11";
            else if (vv1 && a == 3) tag = "R10";
            else if (n == 2) tag = "R6";
            else tag = "R3";
            @(negedge clk);
            check(tag, {int_iss, fp_iss, f2fp, cons}, exp);
          end
        end
      end
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule